// File: doc/BRIEF.md
# ANSI Terminal Sprite Renderer

This block draws a small one-bit sprite, three pixels wide and five lines tall, on a character terminal by producing the byte stream that a terminal interprets as cursor moves and background colour changes. Each "pixel" is one character cell: a space printed with either the chosen foreground background colour (pixel set) or black (pixel clear). The bytes leave on a valid/ready byte port that normally feeds a UART transmitter.

A single-cycle start strobe latches the start row, start column, the two-digit colour code and the five sprite lines, and the engine then streams the whole drawing without further help. The stream opens with a black colour code. Each line begins with a cursor-position command, and each pixel is preceded by a colour code only when its state differs from the colour currently in force. Coordinates are printed in decimal with no leading zero. When the last byte has been accepted, done pulses for one cycle and the engine returns to idle.

Top module: `ansi_sprite_renderer`

## Requirements
- R1: After reset the engine is idle: busy_o, tx_valid_o and done_o are all low, and tx_valid_o stays low whenever busy_o is low.
- R2: A start strobe while idle latches all inputs and the stream begins with the black code 0x1B 0x5B 0x34 0x30 0x6D (ESC [ 4 0 m); the colour-active flag starts as false.
- R3: Sprite line k (k = 0..4) is preceded by ESC [ row ; col H, i.e. 0x1B 0x5B, the row digits, 0x3B, the column digits, 0x48, where row is the latched start row plus k and col is the latched start column.
- R4: Row and column are written as ASCII decimal (0x30 plus digit), valid for values 0 to 99; the tens digit is sent only when the value is 10 or more. The start row must not exceed 95.
- R5: Line k is lines_i[3k+2:3k]; bit 2 is drawn first, then bit 1, then bit 0. Every pixel ends with one space byte 0x20, so each line carries exactly three spaces.
- R6: A set pixel drawn while the active flag is false is preceded by ESC [ t u m (0x1B 0x5B, tens digit, units digit, 0x6D) from fg_code_i, which is always sent as two digits; the flag then becomes true.
- R7: A clear pixel drawn while the active flag is true is preceded by the black code ESC [ 4 0 m; the flag then becomes false.
- R8: No colour code is sent when a pixel matches the active flag, and the flag carries across line boundaries within one sprite.
- R9: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o does not change; no byte is lost or repeated.
- R10: done_o is high for exactly one cycle, the cycle after the last space byte is accepted; busy_o is low in the following cycle.
- R11: A start strobe while busy_o is high is ignored: the stream in progress continues unchanged with the originally latched inputs.
- R12: Every 0x1B byte that is accepted is followed by 0x5B as the next byte offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| row_i | input | 7 | Start row, 0 to 95 |
| col_i | input | 7 | Column, 0 to 99 |
| fg_code_i | input | 7 | Two-digit colour code for set pixels, e.g. 41 |
| lines_i | input | 15 | Sprite lines, line k in bits 3k+2..3k |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| tx_valid_o | output | 1 | Byte on tx_data_o is valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |
| busy_o | output | 1 | Drawing in progress |
| done_o | output | 1 | One-cycle pulse at the end of a drawing |

## Verification
The bench aims at the places where this stream is easy to get subtly wrong: coordinates that cross from one digit to two mid-sprite (a renderer that printed a leading zero or dropped the tens digit would shift the cursor), a colour state that must survive a line break (a design that reset the flag per line would emit a redundant code), sprites that are all set, all clear or alternating, and the two-digit colour code at its upper end. A back-pressured transmitter toggling ready pseudo-randomly exposes any byte that is skipped or duplicated, and a second start strobe issued mid-drawing with different inputs would, in a design that restarted, visibly change the remaining bytes. The done pulse is checked at its exact cycle, so an early or stretched pulse is reported.

// File: rtl/ansi_spr_pkg.sv
package ansi_spr_pkg;

   // byte values used by the stream
   localparam logic [7:0] CH_ESC  = 8'h1B;
   localparam logic [7:0] CH_LBR  = 8'h5B;
   localparam logic [7:0] CH_SEMI = 8'h3B;
   localparam logic [7:0] CH_H    = 8'h48;
   localparam logic [7:0] CH_M    = 8'h6D;
   localparam logic [7:0] CH_SP   = 8'h20;
   localparam logic [7:0] CH_ZERO = 8'h30;

   // black background code digits
   localparam logic [3:0] BLACK_TENS  = 4'd4;
   localparam logic [3:0] BLACK_UNITS = 4'd0;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_BK_ESC, ST_BK_BRK, ST_BK_T, ST_BK_U, ST_BK_M,
      ST_CP_ESC, ST_CP_BRK, ST_ROW_T, ST_ROW_U, ST_SEP,
      ST_COL_T, ST_COL_U, ST_CP_H,
      ST_FG_ESC, ST_FG_BRK, ST_FG_T, ST_FG_U, ST_FG_M,
      ST_SPACE, ST_FIN
   } spr_state_e;

endpackage

// File: rtl/ansi_spr_dec_fmt.sv
module ansi_spr_dec_fmt #(
   parameter int VAL_W = 7
) (
   input  logic [VAL_W-1:0] val_i,
   output logic [3:0]       tens_o,
   output logic [3:0]       units_o,
   output logic             has_tens_o
);

   initial begin
      assert (VAL_W >= 7) else $error("dec_fmt: VAL_W must hold 99");
   end

   localparam int N_THR = 9;

   logic [N_THR-1:0] ge;

   for (genvar k = 1; k <= N_THR; k++) begin : g_thr
      assign ge[k-1] = (val_i >= VAL_W'(10 * k));
   end

   always_comb begin
      tens_o     = 4'($countones(ge));
      units_o    = 4'(val_i - (VAL_W'(tens_o) * VAL_W'(10)));
      has_tens_o = ge[0];
   end

endmodule

// File: rtl/ansi_spr_pix_sel.sv
module ansi_spr_pix_sel #(
   parameter int SPR_W  = 3,
   parameter int SPR_H  = 5,
   parameter int LINE_W = 3,
   parameter int PIX_W  = 2
) (
   input  logic [SPR_W*SPR_H-1:0] lines_i,
   input  logic [LINE_W-1:0]      line_i,
   input  logic [PIX_W-1:0]       pix_i,
   output logic                   pix_o
);

   logic [SPR_W-1:0] rows [SPR_H];

   for (genvar k = 0; k < SPR_H; k++) begin : g_row
      assign rows[k] = lines_i[k*SPR_W +: SPR_W];
   end

   // leftmost pixel is the most significant bit of a line
   logic [PIX_W-1:0] bit_idx;
   assign bit_idx = PIX_W'(SPR_W - 1) - pix_i;

   always_comb begin
      pix_o = 1'b0;
      if (int'(line_i) < SPR_H && int'(bit_idx) < SPR_W)
         pix_o = rows[line_i][bit_idx];
   end

endmodule

// File: rtl/ansi_spr_byte_mux.sv
module ansi_spr_byte_mux
   import ansi_spr_pkg::*;
(
   input  spr_state_e  state_i,
   input  logic [3:0]  row_tens_i,
   input  logic [3:0]  row_units_i,
   input  logic [3:0]  col_tens_i,
   input  logic [3:0]  col_units_i,
   input  logic [3:0]  fg_tens_i,
   input  logic [3:0]  fg_units_i,
   output logic [7:0]  byte_o
);

   function automatic logic [7:0] digit(input logic [3:0] d);
      return CH_ZERO + {4'b0, d};
   endfunction

   always_comb begin
      unique case (state_i)
         ST_BK_ESC, ST_CP_ESC, ST_FG_ESC: byte_o = CH_ESC;
         ST_BK_BRK, ST_CP_BRK, ST_FG_BRK: byte_o = CH_LBR;
         ST_BK_T:  byte_o = digit(BLACK_TENS);
         ST_BK_U:  byte_o = digit(BLACK_UNITS);
         ST_BK_M, ST_FG_M: byte_o = CH_M;
         ST_ROW_T: byte_o = digit(row_tens_i);
         ST_ROW_U: byte_o = digit(row_units_i);
         ST_SEP:   byte_o = CH_SEMI;
         ST_COL_T: byte_o = digit(col_tens_i);
         ST_COL_U: byte_o = digit(col_units_i);
         ST_CP_H:  byte_o = CH_H;
         ST_FG_T:  byte_o = digit(fg_tens_i);
         ST_FG_U:  byte_o = digit(fg_units_i);
         ST_SPACE: byte_o = CH_SP;
         default:  byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/ansi_spr_ctrl.sv
module ansi_spr_ctrl
   import ansi_spr_pkg::*;
#(
   parameter int SPR_W   = 3,
   parameter int SPR_H   = 5,
   parameter int COORD_W = 7,
   parameter int LINE_W  = 3,
   parameter int PIX_W   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [COORD_W-1:0]     row_i,
   input  logic [COORD_W-1:0]     col_i,
   input  logic [COORD_W-1:0]     fg_i,
   input  logic [SPR_W*SPR_H-1:0] lines_i,
   input  logic                   tx_ready_i,
   input  logic                   pix_bit_i,
   input  logic                   row_has_tens_i,
   input  logic                   col_has_tens_i,
   output spr_state_e             state_o,
   output logic [LINE_W-1:0]      line_o,
   output logic [PIX_W-1:0]       sel_pix_o,
   output logic [COORD_W-1:0]     row_cur_o,
   output logic [COORD_W-1:0]     col_o,
   output logic [COORD_W-1:0]     fg_o,
   output logic [SPR_W*SPR_H-1:0] lines_o,
   output logic                   tx_valid_o,
   output logic                   busy_o,
   output logic                   done_o
);

   localparam logic [PIX_W-1:0]  LAST_PIX  = PIX_W'(SPR_W - 1);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(SPR_H - 1);

   spr_state_e               state_q, state_d;
   logic [LINE_W-1:0]        line_q;
   logic [PIX_W-1:0]         pix_q;
   logic [COORD_W-1:0]       row_q, col_q, fg_q;
   logic [SPR_W*SPR_H-1:0]   lines_q;
   logic                     active_q;
   logic                     opening_q;
   logic                     fire;
   logic                     last_pix;

   assign tx_valid_o = (state_q != ST_IDLE) && (state_q != ST_FIN);
   assign fire       = tx_valid_o && tx_ready_i;
   assign last_pix   = (pix_q == LAST_PIX);

   // the selector looks one pixel ahead while a space is on the port
   assign sel_pix_o = (state_q == ST_SPACE && !last_pix) ? pix_q + PIX_W'(1) : pix_q;

   function automatic spr_state_e colour_step(input logic lit, input logic act);
      if (lit && !act)      return ST_FG_ESC;
      else if (!lit && act) return ST_BK_ESC;
      else                  return ST_SPACE;
   endfunction

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i) state_d = ST_BK_ESC;
         ST_FIN:    state_d = ST_IDLE;
         default: begin
            if (fire) begin
               unique case (state_q)
                  ST_BK_ESC: state_d = ST_BK_BRK;
                  ST_BK_BRK: state_d = ST_BK_T;
                  ST_BK_T:   state_d = ST_BK_U;
                  ST_BK_U:   state_d = ST_BK_M;
                  ST_BK_M:   state_d = opening_q ? ST_CP_ESC : ST_SPACE;
                  ST_CP_ESC: state_d = ST_CP_BRK;
                  ST_CP_BRK: state_d = row_has_tens_i ? ST_ROW_T : ST_ROW_U;
                  ST_ROW_T:  state_d = ST_ROW_U;
                  ST_ROW_U:  state_d = ST_SEP;
                  ST_SEP:    state_d = col_has_tens_i ? ST_COL_T : ST_COL_U;
                  ST_COL_T:  state_d = ST_COL_U;
                  ST_COL_U:  state_d = ST_CP_H;
                  ST_CP_H:   state_d = colour_step(pix_bit_i, active_q);
                  ST_FG_ESC: state_d = ST_FG_BRK;
                  ST_FG_BRK: state_d = ST_FG_T;
                  ST_FG_T:   state_d = ST_FG_U;
                  ST_FG_U:   state_d = ST_FG_M;
                  ST_FG_M:   state_d = ST_SPACE;
                  ST_SPACE: begin
                     if (!last_pix)              state_d = colour_step(pix_bit_i, active_q);
                     else if (line_q == LAST_LINE) state_d = ST_FIN;
                     else                        state_d = ST_CP_ESC;
                  end
                  default:   state_d = ST_IDLE;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         line_q    <= '0;
         pix_q     <= '0;
         row_q     <= '0;
         col_q     <= '0;
         fg_q      <= '0;
         lines_q   <= '0;
         active_q  <= 1'b0;
         opening_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) begin
            row_q     <= row_i;
            col_q     <= col_i;
            fg_q      <= fg_i;
            lines_q   <= lines_i;
            line_q    <= '0;
            pix_q     <= '0;
            active_q  <= 1'b0;
            opening_q <= 1'b1;
         end else if (fire) begin
            unique case (state_q)
               ST_BK_M: begin
                  active_q  <= 1'b0;
                  opening_q <= 1'b0;
               end
               ST_FG_M: active_q <= 1'b1;
               ST_SPACE: begin
                  if (last_pix) begin
                     pix_q <= '0;
                     if (line_q != LAST_LINE) begin
                        line_q <= line_q + LINE_W'(1);
                        row_q  <= row_q + COORD_W'(1);
                     end
                  end else begin
                     pix_q <= pix_q + PIX_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign state_o   = state_q;
   assign line_o    = line_q;
   assign row_cur_o = row_q;
   assign col_o     = col_q;
   assign fg_o      = fg_q;
   assign lines_o   = lines_q;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_FIN);

endmodule

// File: rtl/ansi_sprite_renderer.sv
module ansi_sprite_renderer
   import ansi_spr_pkg::*;
#(
   parameter int SPR_W   = 3,
   parameter int SPR_H   = 5,
   parameter int COORD_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [COORD_W-1:0]     row_i,
   input  logic [COORD_W-1:0]     col_i,
   input  logic [COORD_W-1:0]     fg_code_i,
   input  logic [SPR_W*SPR_H-1:0] lines_i,
   output logic [7:0]             tx_data_o,
   output logic                   tx_valid_o,
   input  logic                   tx_ready_i,
   output logic                   busy_o,
   output logic                   done_o
);

   localparam int LINE_W = (SPR_H > 1) ? $clog2(SPR_H) : 1;
   localparam int PIX_W  = (SPR_W > 1) ? $clog2(SPR_W) : 1;

   initial begin
      assert (SPR_W >= 1 && SPR_W <= 16) else $error("renderer: SPR_W out of range");
      assert (SPR_H >= 1 && SPR_H <= 64) else $error("renderer: SPR_H out of range");
      assert (COORD_W >= 7)              else $error("renderer: COORD_W must hold 99");
   end

   spr_state_e               state;
   logic [LINE_W-1:0]        line_idx;
   logic [PIX_W-1:0]         sel_pix;
   logic [COORD_W-1:0]       row_cur, col_lat, fg_lat;
   logic [SPR_W*SPR_H-1:0]   lines_lat;
   logic                     pix_bit;
   logic [3:0]               row_t, row_u, col_t, col_u, fg_t, fg_u;
   logic                     row_ht, col_ht, fg_ht;

   ansi_spr_ctrl #(
      .SPR_W(SPR_W), .SPR_H(SPR_H), .COORD_W(COORD_W),
      .LINE_W(LINE_W), .PIX_W(PIX_W)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .row_i          (row_i),
      .col_i          (col_i),
      .fg_i           (fg_code_i),
      .lines_i        (lines_i),
      .tx_ready_i     (tx_ready_i),
      .pix_bit_i      (pix_bit),
      .row_has_tens_i (row_ht),
      .col_has_tens_i (col_ht),
      .state_o        (state),
      .line_o         (line_idx),
      .sel_pix_o      (sel_pix),
      .row_cur_o      (row_cur),
      .col_o          (col_lat),
      .fg_o           (fg_lat),
      .lines_o        (lines_lat),
      .tx_valid_o     (tx_valid_o),
      .busy_o         (busy_o),
      .done_o         (done_o)
   );

   ansi_spr_pix_sel #(
      .SPR_W(SPR_W), .SPR_H(SPR_H), .LINE_W(LINE_W), .PIX_W(PIX_W)
   ) u_sel (
      .lines_i (lines_lat),
      .line_i  (line_idx),
      .pix_i   (sel_pix),
      .pix_o   (pix_bit)
   );

   ansi_spr_dec_fmt #(.VAL_W(COORD_W)) u_row_fmt (
      .val_i(row_cur), .tens_o(row_t), .units_o(row_u), .has_tens_o(row_ht)
   );

   ansi_spr_dec_fmt #(.VAL_W(COORD_W)) u_col_fmt (
      .val_i(col_lat), .tens_o(col_t), .units_o(col_u), .has_tens_o(col_ht)
   );

   ansi_spr_dec_fmt #(.VAL_W(COORD_W)) u_fg_fmt (
      .val_i(fg_lat), .tens_o(fg_t), .units_o(fg_u), .has_tens_o(fg_ht)
   );

   ansi_spr_byte_mux u_mux (
      .state_i     (state),
      .row_tens_i  (row_t),
      .row_units_i (row_u),
      .col_tens_i  (col_t),
      .col_units_i (col_u),
      .fg_tens_i   (fg_t),
      .fg_units_i  (fg_u),
      .byte_o      (tx_data_o)
   );

   // the colour code is always two digits, so its tens flag is unused
   logic unused_fg_ht;
   assign unused_fg_ht = fg_ht;

endmodule

// File: rtl/ansi_sprite_renderer_chk.sv
module ansi_sprite_renderer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic [7:0] tx_data_o,
   input logic       tx_valid_o,
   input logic       tx_ready_i,
   input logic       busy_o,
   input logic       done_o
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !tx_valid_o);

   assert_open_esc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (tx_valid_o && tx_data_o == 8'h1B));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(tx_valid_o && tx_ready_i));

   assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && start_i) |=> busy_o);

   assert_esc_brk_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_ready_i && tx_data_o == 8'h1B) |=> (tx_valid_o && tx_data_o == 8'h5B));

endmodule

bind ansi_sprite_renderer ansi_sprite_renderer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .tx_data_o  (tx_data_o),
   .tx_valid_o (tx_valid_o),
   .tx_ready_i (tx_ready_i),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/ansi_sprite_renderer_tb_top.sv
module ansi_sprite_renderer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [6:0]  row_i = '0;
   logic [6:0]  col_i = '0;
   logic [6:0]  fg_code_i = '0;
   logic [14:0] lines_i = '0;
   logic [7:0]  tx_data_o;
   logic        tx_valid_o;
   logic        tx_ready_i = 1'b0;
   logic        busy_o;
   logic        done_o;

   always #4 clk = ~clk;

   ansi_sprite_renderer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .row_i      (row_i),
      .col_i      (col_i),
      .fg_code_i  (fg_code_i),
      .lines_i    (lines_i),
      .tx_data_o  (tx_data_o),
      .tx_valid_o (tx_valid_o),
      .tx_ready_i (tx_ready_i),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit wd    = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   bit         rnd_mode    = 1'b0;
   bit         expect_done = 1'b0;
   bit         done_seen   = 1'b0;
   bit         prev_stall  = 1'b0;
   logic [7:0] prev_data   = '0;
   logic [15:0] lfsr       = 16'hACE1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input int b, input string tag);
      exp_q.push_back(8'(b));
      tag_q.push_back(tag);
   endtask

   task automatic push_dec(input int v, input string tag);
      if (v >= 10) push(8'h30 + v / 10, tag);
      push(8'h30 + v % 10, tag);
   endtask

   task automatic push_black(input string tag);
      push(8'h1B, "R12"); push(8'h5B, "R12");
      push(8'h34, tag); push(8'h30, tag); push(8'h6D, tag);
   endtask

   // scoreboard model built from the requirements
   task automatic build_expected(input int row, input int col, input int fg, input logic [14:0] lines);
      bit act;
      bit lit;
      bit coded;
      push_black("R2");
      act = 1'b0;
      for (int k = 0; k < 5; k++) begin
         push(8'h1B, "R12"); push(8'h5B, "R12");
         push_dec(row + k, "R4");
         push(8'h3B, "R3");
         push_dec(col, "R4");
         push(8'h48, "R3");
         for (int p = 2; p >= 0; p--) begin
            lit   = lines[3*k + p];
            coded = 1'b0;
            if (lit && !act) begin
               push(8'h1B, "R12"); push(8'h5B, "R12");
               push(8'h30 + fg / 10, "R6"); push(8'h30 + fg % 10, "R6");
               push(8'h6D, "R6");
               act = 1'b1; coded = 1'b1;
            end else if (!lit && act) begin
               push_black("R7");
               act = 1'b0; coded = 1'b1;
            end
            push(8'h20, coded ? "R5" : "R8");
         end
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !wd) begin
         wd = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
      end
   end

   // monitor: drives ready, checks every accepted byte and the done pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall)
            check(tx_valid_o && tx_data_o == prev_data, "R9 held byte", int'(tx_data_o), int'(prev_data));
         if (expect_done) begin
            check(done_o == 1'b1, "R10 done pulse", int'(done_o), 1);
            expect_done = 1'b0;
            done_seen   = 1'b1;
         end else if (done_o) begin
            check(1'b0, "R10 stray done", 1, 0);
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tx_ready_i = rnd_mode ? lfsr[0] : 1'b1;
         if (tx_valid_o && tx_ready_i) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected byte", int'(tx_data_o), 0);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(tx_data_o == e, t, int'(tx_data_o), int'(e));
               if (exp_q.size() == 0) expect_done = 1'b1;
            end
         end
         prev_stall = tx_valid_o && !tx_ready_i;
         prev_data  = tx_data_o;
      end
   end

   task automatic run_sprite(input int row, input int col, input int fg,
                             input logic [14:0] lines, input bit rnd, input bit interfere);
      @(negedge clk);
      row_i = 7'(row); col_i = 7'(col); fg_code_i = 7'(fg); lines_i = lines;
      rnd_mode  = rnd;
      done_seen = 1'b0;
      build_expected(row, col, fg, lines);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      row_i = 7'd50; col_i = 7'd50; fg_code_i = 7'd45; lines_i = ~lines;
      if (interfere) begin
         repeat (20) @(negedge clk);
         check(busy_o == 1'b1, "R11 busy before second start", int'(busy_o), 1);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check(busy_o == 1'b1, "R11 busy after second start", int'(busy_o), 1);
      end
      while (!done_seen && !wd) @(negedge clk);
      @(negedge clk);
      check(busy_o == 1'b0, "R10 idle after done", int'(busy_o), 0);
      check(exp_q.size() == 0, "R5 stream complete", exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o == 1'b0,     "R1 busy at reset",  int'(busy_o), 0);
      check(tx_valid_o == 1'b0, "R1 valid at reset", int'(tx_valid_o), 0);
      check(done_o == 1'b0,     "R1 done at reset",  int'(done_o), 0);

      // all pixels set, single-digit coordinates
      if (!wd) run_sprite(3, 7, 41, 15'h7FFF, 1'b0, 1'b0);
      // cross shape, two-digit coordinates, back-pressure
      if (!wd) run_sprite(12, 40, 42, {3'b101, 3'b000, 3'b010, 3'b111, 3'b010}, 1'b1, 1'b0);
      // nothing set, origin
      if (!wd) run_sprite(0, 0, 47, 15'h0000, 1'b1, 1'b0);
      // alternating, top of the coordinate range
      if (!wd) run_sprite(95, 99, 44, {3'b101, 3'b010, 3'b101, 3'b010, 3'b101}, 1'b0, 1'b0);
      // row crosses from one to two digits; a second start mid-drawing
      if (!wd) run_sprite(8, 9, 41, {3'b110, 3'b011, 3'b100, 3'b001, 3'b010}, 1'b1, 1'b1);
      // colour state carried over a line break, largest colour code
      if (!wd) run_sprite(20, 10, 99, {3'b000, 3'b111, 3'b001, 3'b100, 3'b001}, 1'b1, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule